// File: doc/BRIEF.md
# First-Level Table Address Generator

This block sits in front of the page-table walker of a memory management unit. It holds two translation-table base registers, a 3-bit table-split control value and a domain access control word. For each virtual address that is handed to it, it works out which of the two tables covers that address and forms the physical address of the first-level descriptor. When the walker returns the fetched descriptor, the block reports the descriptor's type and the 2-bit access value of the domain that the descriptor names.

The split between the two tables is programmable. The control value N selects the top N virtual address bits. An address with any of those bits set is served from base 1. When N is larger, the table reached through base 0 is smaller, so fewer low bits of base 0 are dropped. The registers are reached through a simple write/read port, and lookups use a valid/ready request followed by a descriptor-return strobe.

Top module: `ttb_selector`

## Requirements
- R1: After a synchronous reset, the register port reads all four registers as zero and `req_ready` is 1. `desc_addr_valid` and `res_valid` are 0. The table split starts at N = 0.
- R2: A write to the control register (select 2) stores only `reg_wdata[2:0]`. Reading select 2 returns that N with all upper bits zero.
- R3: The register select codes are 0 for base 0, 1 for base 1, 2 for control and 3 for domain access control. `reg_rdata` is registered: it shows the register chosen by `reg_sel` at the previous edge, with the value it held before any write on that same edge.
- R4: With N = 0, every virtual address is served from base 0.
- R5: With N > 0, a virtual address that has any of its top N bits set is served from base 1. Any other address is served from base 0.
- R6: When base 1 serves an address, the table address is base 1 with bits [13:0] cleared, whatever the value of N.
- R7: When base 0 serves an address, the table address is base 0 with bits [13-N:0] cleared.
- R8: The descriptor address places virtual address bits [31:20] at bits [13:2] and has bits [1:0] at zero.
- R9: A request is accepted on an edge where `req_valid` and `req_ready` are both 1. From the next cycle, `desc_addr_valid` is 1 and `desc_addr` is stable. `req_ready` stays 0 until the descriptor returns.
- R10: On the edge where `desc_valid` is seen during a pending lookup, the block raises `res_valid` for exactly one cycle. In that cycle `res_type` holds descriptor bits [1:0`]`, and `res_dom_ap` holds bits [2D+1:2D] of the domain access register, where D is descriptor bits [8:5].
- R11: A control write is used by a lookup that is accepted in the very next cycle.
- R12: A `desc_valid` pulse while no lookup is pending produces no result and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 base 0, 1 base 1, 2 control, 3 domain access) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the selected register |
| req_valid | input | 1 | Lookup request valid |
| req_ready | output | 1 | Block can accept a lookup |
| req_vaddr | input | 32 | Virtual address to look up |
| desc_addr_valid | output | 1 | Descriptor address is valid; fetch pending |
| desc_addr | output | 32 | Physical address of the first-level descriptor |
| desc_valid | input | 1 | Fetched descriptor is present |
| desc_data | input | 32 | Fetched first-level descriptor |
| res_valid | output | 1 | One-cycle result strobe |
| res_type | output | 2 | Descriptor type field |
| res_dom_ap | output | 2 | Access value of the descriptor's domain |

## Verification
The assertions assume that `desc_valid` only matters while a fetch is pending, and that the walker never holds it high across the result cycle as part of a second lookup. The stimulus drives every input on the falling edge. It raises `desc_valid` for one cycle per fetch, after a delay of zero to several cycles, and sends only one isolated stray strobe while the block is idle. Register writes are placed both between lookups and while a fetch is pending. This exercises the rule that a lookup captures its address when it is accepted.

// File: rtl/ttb_pkg.sv
package ttb_pkg;
  typedef enum logic [1:0] {
    SEL_BASE0 = 2'd0,
    SEL_BASE1 = 2'd1,
    SEL_CTRL  = 2'd2,
    SEL_DACR  = 2'd3
  } reg_sel_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } lk_state_e;
endpackage

// File: rtl/ttb_regs.sv
module ttb_regs #(
  parameter int AW       = 32,
  parameter int CW       = 3,
  parameter int TBL_BITS = 14
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [1:0]    sel,
  input  logic [AW-1:0] wdata,
  output logic [AW-1:0] rdata,
  output logic [AW-1:0] base0,
  output logic [AW-1:0] base1,
  output logic [AW-1:0] dacr,
  output logic [AW-1:0] sel_mask,
  output logic [AW-1:0] b0_mask
);
  import ttb_pkg::*;

  localparam logic [AW-1:0] LOW_ONES = AW'((64'd1 << TBL_BITS) - 64'd1);
  localparam logic [AW-1:0] ALL_ONES = {AW{1'b1}};

  logic [CW-1:0] ctrl;
  logic [CW-1:0] n_new;

  assign n_new = wdata[CW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      base0    <= '0;
      base1    <= '0;
      dacr     <= '0;
      ctrl     <= '0;
      sel_mask <= '0;
      b0_mask  <= ~LOW_ONES;
      rdata    <= '0;
    end else begin
      case (reg_sel_e'(sel))
        SEL_BASE0: rdata <= base0;
        SEL_BASE1: rdata <= base1;
        SEL_CTRL:  rdata <= AW'(ctrl);
        default:   rdata <= dacr;
      endcase
      if (wr_en) begin
        case (reg_sel_e'(sel))
          SEL_BASE0: base0 <= wdata;
          SEL_BASE1: base1 <= wdata;
          SEL_CTRL: begin
            ctrl     <= n_new;
            sel_mask <= ~(ALL_ONES >> n_new);
            b0_mask  <= ~(LOW_ONES >> n_new);
          end
          default:   dacr <= wdata;
        endcase
      end
    end
  end

  AST_SPLIT_ZERO: assert property (@(posedge clk) disable iff (rst)
    (ctrl == '0) |-> (sel_mask == '0)) else $error("split mask set with N=0"); // R4

  AST_B0_TOP_KEPT: assert property (@(posedge clk) disable iff (rst)
    (b0_mask[AW-1:TBL_BITS] == {(AW-TBL_BITS){1'b1}})) else $error("base0 mask lost high bits"); // R7

  AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && sel == SEL_CTRL) |=> (ctrl == $past(wdata[CW-1:0]))) else $error("control write"); // R2
endmodule

// File: rtl/ttb_addr_gen.sv
module ttb_addr_gen #(
  parameter int AW       = 32,
  parameter int SEC_BITS = 20,
  parameter int TBL_BITS = 14
) (
  input  logic [AW-1:0] vaddr,
  input  logic [AW-1:0] base0,
  input  logic [AW-1:0] base1,
  input  logic [AW-1:0] sel_mask,
  input  logic [AW-1:0] b0_mask,
  output logic [AW-1:0] l1_addr
);
  localparam int IDX_W = AW - SEC_BITS;
  localparam logic [AW-1:0] B1_MASK = ~AW'((64'd1 << TBL_BITS) - 64'd1);

  logic          use_b1;
  logic [AW-1:0] table_base;
  logic [AW-1:0] index;

  assign use_b1     = |(vaddr & sel_mask);
  assign table_base = use_b1 ? (base1 & B1_MASK) : (base0 & b0_mask);
  assign index      = {{(AW-IDX_W-2){1'b0}}, vaddr[AW-1:SEC_BITS], 2'b00};
  assign l1_addr    = table_base | index;
endmodule

// File: rtl/ttb_dom_extract.sv
module ttb_dom_extract #(
  parameter int AW    = 32,
  parameter int DOM_W = 4
) (
  input  logic [AW-1:0]    dacr,
  input  logic [DOM_W-1:0] dom,
  output logic [1:0]       ap
);
  localparam int NUM_DOM = AW / 2;

  logic [1:0] fields [NUM_DOM];

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
    assign fields[g] = dacr[2*g +: 2];
  end

  assign ap = fields[dom];
endmodule

// File: rtl/ttb_lookup_fsm.sv
module ttb_lookup_fsm #(
  parameter int AW    = 32,
  parameter int DOM_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [AW-1:0]    addr_in,
  output logic             desc_addr_valid,
  output logic [AW-1:0]    desc_addr,
  input  logic             desc_valid,
  input  logic [1:0]       desc_type,
  input  logic [1:0]       dom_ap,
  output logic             res_valid,
  output logic [1:0]       res_type,
  output logic [1:0]       res_dom_ap
);
  import ttb_pkg::*;

  lk_state_e state;

  assign req_ready       = (state == ST_IDLE);
  assign desc_addr_valid = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      desc_addr  <= '0;
      res_valid  <= 1'b0;
      res_type   <= '0;
      res_dom_ap <= '0;
    end else begin
      res_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (req_valid) begin
            desc_addr <= addr_in;
            state     <= ST_WAIT;
          end
        end
        default: begin
          if (desc_valid) begin
            res_valid  <= 1'b1;
            res_type   <= desc_type;
            res_dom_ap <= dom_ap;
            state      <= ST_IDLE;
          end
        end
      endcase
    end
  end

  AST_ACCEPT_ISSUES: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> desc_addr_valid) else $error("accept did not issue"); // R9

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    desc_addr_valid |-> !req_ready) else $error("ready while pending"); // R9

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst)
    (desc_addr_valid && $past(desc_addr_valid)) |-> $stable(desc_addr)) else $error("address moved"); // R9

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    desc_addr_valid |-> (desc_addr[1:0] == 2'b00)) else $error("address not word aligned"); // R8

  AST_RES_PULSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid) else $error("result longer than one cycle"); // R10

  AST_RES_CAUSE: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> ($past(desc_valid) && $past(desc_addr_valid))) else $error("result without pending fetch"); // R12
endmodule

// File: rtl/ttb_selector.sv
module ttb_selector #(
  parameter int AW       = 32,
  parameter int CW       = 3,
  parameter int SEC_BITS = 20,
  parameter int DOM_W    = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          reg_wr_en,
  input  logic [1:0]    reg_sel,
  input  logic [AW-1:0] reg_wdata,
  output logic [AW-1:0] reg_rdata,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_vaddr,
  output logic          desc_addr_valid,
  output logic [AW-1:0] desc_addr,
  input  logic          desc_valid,
  input  logic [AW-1:0] desc_data,
  output logic          res_valid,
  output logic [1:0]    res_type,
  output logic [1:0]    res_dom_ap
);
  localparam int TBL_BITS = AW - SEC_BITS + 2;
  localparam int DOM_LSB  = 5;

  logic [AW-1:0] base0, base1, dacr, sel_mask, b0_mask, l1_addr;
  logic [1:0]    dom_ap;

  ttb_regs #(.AW(AW), .CW(CW), .TBL_BITS(TBL_BITS)) regs_i (
    .clk(clk), .rst(rst), .wr_en(reg_wr_en), .sel(reg_sel), .wdata(reg_wdata),
    .rdata(reg_rdata), .base0(base0), .base1(base1), .dacr(dacr),
    .sel_mask(sel_mask), .b0_mask(b0_mask)
  );

  ttb_addr_gen #(.AW(AW), .SEC_BITS(SEC_BITS), .TBL_BITS(TBL_BITS)) addr_i (
    .vaddr(req_vaddr), .base0(base0), .base1(base1), .sel_mask(sel_mask),
    .b0_mask(b0_mask), .l1_addr(l1_addr)
  );

  ttb_dom_extract #(.AW(AW), .DOM_W(DOM_W)) dom_i (
    .dacr(dacr), .dom(desc_data[DOM_LSB +: DOM_W]), .ap(dom_ap)
  );

  ttb_lookup_fsm #(.AW(AW), .DOM_W(DOM_W)) fsm_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .addr_in(l1_addr), .desc_addr_valid(desc_addr_valid), .desc_addr(desc_addr),
    .desc_valid(desc_valid), .desc_type(desc_data[1:0]), .dom_ap(dom_ap),
    .res_valid(res_valid), .res_type(res_type), .res_dom_ap(res_dom_ap)
  );
endmodule

// File: tb/ttb_selector_tb.sv
module ttb_selector_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        reg_wr_en;
  logic [1:0]  reg_sel;
  logic [31:0] reg_wdata, reg_rdata;
  logic        req_valid, req_ready;
  logic [31:0] req_vaddr;
  logic        desc_addr_valid;
  logic [31:0] desc_addr;
  logic        desc_valid;
  logic [31:0] desc_data;
  logic        res_valid;
  logic [1:0]  res_type, res_dom_ap;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cycles   = 0;
  string phase    = "R1";

  // reference model state
  logic [31:0] m_b0, m_b1, m_dacr, m_addr, m_rdata;
  int          m_n;
  logic        m_pend, m_resv;
  logic [1:0]  m_type, m_ap;

  always #10 clk = ~clk;

  ttb_selector dut_i (
    .clk(clk), .rst(rst), .reg_wr_en(reg_wr_en), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
    .req_ready(req_ready), .req_vaddr(req_vaddr), .desc_addr_valid(desc_addr_valid),
    .desc_addr(desc_addr), .desc_valid(desc_valid), .desc_data(desc_data),
    .res_valid(res_valid), .res_type(res_type), .res_dom_ap(res_dom_ap)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: actual 0x%08h expected 0x%08h", req, cycles, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_addr(input logic [31:0] va);
    logic hi;
    logic [31:0] t;
    hi = (m_n != 0) && ((va >> (32 - m_n)) != 0);
    if (hi) t = m_b1 & 32'hFFFF_C000;
    else    t = m_b0 & ~(32'h0000_3FFF >> m_n);
    return t | ((va >> 18) & 32'h0000_3FFC);
  endfunction

  // behavioural model, evaluated on the values present at each rising edge
  always @(posedge clk) begin
    cycles++;
    if (rst) begin
      m_b0 = 0; m_b1 = 0; m_dacr = 0; m_n = 0; m_addr = 0; m_rdata = 0;
      m_pend = 0; m_resv = 0; m_type = 0; m_ap = 0;
    end else begin
      case (reg_sel)
        2'd0: m_rdata = m_b0;
        2'd1: m_rdata = m_b1;
        2'd2: m_rdata = 32'(m_n);
        default: m_rdata = m_dacr;
      endcase
      m_resv = 0;
      if (m_pend) begin
        if (desc_valid) begin
          m_resv = 1;
          m_type = desc_data[1:0];
          m_ap   = 2'((m_dacr >> ((desc_data >> 4) & 32'h1E)) & 32'h3);
          m_pend = 0;
        end
      end else if (req_valid) begin
        m_addr = ref_addr(req_vaddr);
        m_pend = 1;
      end
      if (reg_wr_en) begin
        case (reg_sel)
          2'd0: m_b0 = reg_wdata;
          2'd1: m_b1 = reg_wdata;
          2'd2: m_n = int'(reg_wdata & 32'h7);
          default: m_dacr = reg_wdata;
        endcase
      end
    end
  end

  // compare on every falling edge
  always @(negedge clk) begin
    if (!rst) begin
      chk({phase, " R3 rdata"}, reg_rdata, m_rdata);
      chk({phase, " R9 ready"}, 32'(req_ready), 32'(!m_pend));
      chk({phase, " R9 addr_valid"}, 32'(desc_addr_valid), 32'(m_pend));
      if (m_pend) chk({phase, " R4 R5 R6 R7 R8 addr"}, desc_addr, m_addr);
      chk({phase, " R10 R12 res_valid"}, 32'(res_valid), 32'(m_resv));
      if (m_resv) begin
        chk({phase, " R10 type"}, 32'(res_type), 32'(m_type));
        chk({phase, " R10 dom_ap"}, 32'(res_dom_ap), 32'(m_ap));
      end
    end
  end

  task automatic wr(input logic [1:0] s, input logic [31:0] d);
    reg_wr_en = 1; reg_sel = s; reg_wdata = d;
    @(negedge clk);
    reg_wr_en = 0;
  endtask

  task automatic rd(input logic [1:0] s);
    reg_sel = s;
    @(negedge clk);
  endtask

  task automatic lookup(input logic [31:0] va, input logic [31:0] desc, input int dly);
    req_valid = 1; req_vaddr = va;
    @(negedge clk);
    req_valid = 0;
    repeat (dly) @(negedge clk);
    desc_valid = 1; desc_data = desc;
    @(negedge clk);
    desc_valid = 0;
    @(negedge clk);
  endtask

  initial begin
    rst = 1; reg_wr_en = 0; reg_sel = 0; reg_wdata = 0;
    req_valid = 0; req_vaddr = 0; desc_valid = 0; desc_data = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1: reset values seen through the port
    chk("R1 ready", 32'(req_ready), 1);
    chk("R1 res_valid", 32'(res_valid), 0);
    for (int s = 0; s < 4; s++) begin
      rd(2'(s));
      chk("R1 reset read", reg_rdata, 0);
    end
    // R3: all four registers
    phase = "R3";
    wr(2'd0, 32'h1234_5678);
    wr(2'd1, 32'hDEAD_BEEF);
    wr(2'd3, 32'hE4E4_1B1B);
    for (int s = 0; s < 4; s++) rd(2'(s));
    // R4: N=0, every address uses base 0
    phase = "R4";
    lookup(32'hFFF0_0000, 32'h0000_0012, 0);
    lookup(32'h8000_0000, 32'h0000_01E1, 2);
    lookup(32'h0010_0000, 32'h0000_00A3, 1);
    // R2: only low 3 bits kept
    phase = "R2";
    wr(2'd2, 32'hFFFF_FFFD);
    rd(2'd2);
    rd(2'd2);
    chk("R2 control readback", reg_rdata, 32'd5);
    // R11: control write then lookup in the very next cycle
    phase = "R11";
    wr(2'd2, 32'd1);
    lookup(32'h8000_0000, 32'h2, 0);
    chk("R11 R5 base1 picked", 32'(res_valid), 0);
    // R5 R6 R7: sweep N
    for (int n = 0; n < 8; n++) begin
      phase = "R5 R6 R7";
      wr(2'd2, 32'(n));
      wr(2'd0, 32'hFFFF_FFFF);
      wr(2'd1, 32'hA5A5_A5A5 ^ 32'(n));
      lookup(32'h0000_0000, 32'(n * 32), 0);
      lookup(32'hFFFF_FFFF, 32'(n * 37), 1);
      lookup(32'h1 << (32 - (n == 0 ? 1 : n)), 32'h1F3, 0);
      lookup(32'h0FF0_0000 >> n, 32'h0E2, 0);
    end
    // R12: stray descriptor strobe while idle
    phase = "R12";
    desc_valid = 1; desc_data = 32'h1E3;
    @(negedge clk);
    desc_valid = 0;
    @(negedge clk);
    chk("R12 no result", 32'(res_valid), 0);
    // R10: every domain
    phase = "R10";
    wr(2'd3, 32'h9C63_E41B);
    for (int d = 0; d < 16; d++) lookup(32'(d) << 24, 32'((d << 5) | (d & 3) | 32'h0010_0010), d % 3);
    // R9: long wait with writes while pending
    phase = "R9";
    req_valid = 1; req_vaddr = 32'h4560_0000;
    @(negedge clk);
    req_valid = 0;
    wr(2'd0, 32'h0);
    wr(2'd2, 32'd7);
    req_valid = 1; req_vaddr = 32'hFFFF_FFFF;
    repeat (3) @(negedge clk);
    chk("R9 still pending", 32'(req_ready), 0);
    req_valid = 0;
    desc_valid = 1; desc_data = 32'h3;
    @(negedge clk);
    desc_valid = 0;
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule